// File: doc/BRIEF.md
# List-Driven Block Copy Engine

This engine moves blocks of data between a local store and a remote address space, one command at a time. A command is either a single block, or a gather list whose elements sit in the local store and are walked in order. A block is described by a local address, a remote address and a byte size. In the get direction the remote side is the source and the local side the destination. In the put direction the two sides swap.

Each block is cut into beats as wide as the data path. For every beat the engine reads one word from the source port and then writes it to the destination port. Both ports use a simple request/ready handshake. For a list command the local address runs on contiguously from one element to the next, while every element brings its own remote address. A one-cycle completion pulse returns the command's tag and an error flag. While a command is in progress the engine reports busy and takes no new command.

Top module: `dma_list_engine`

## Requirements
- R1: A get command (cmd_put=0) reads each beat from the remote port and writes it to the local port at the matching offset.
- R2: A put command (cmd_put=1) reads each beat from the local port and writes it to the remote port at the matching offset.
- R3: A block size of zero, or a size above MAX_BLOCK bytes, is rejected: done_err=1 and neither port is written.
- R4: A size that is not a whole number of beats (BEAT_B = DATA_W/8 bytes), or a local or remote address that is not a multiple of BEAT_B, is rejected with done_err=1 and no write. Every address presented on either port is a multiple of BEAT_B.
- R5: A list command whose element count is outside MIN_LIST..MAX_LIST, or whose list address is not beat aligned, is rejected with done_err=1 and no write.
- R6: List element i is one word read from the local port at cmd_list_addr + i*BEAT_B. Bits [ADDR_W-1:0] of that word hold the remote address and bits [ADDR_W+SZ_W-1:ADDR_W] hold the size. Elements run strictly in order. The local address of each element is the previous element's local address plus its size, starting at cmd_laddr.
- R7: A request held with ready low keeps its address, direction and write data unchanged in the next cycle. A stall on either side loses no data.
- R8: done is a one-cycle pulse that follows the final write of the final element. It carries the command's tag on done_tag, and done_err=0 when every block was accepted.
- R9: busy is low with both ports idle after reset and between commands. busy rises in the cycle after a command is taken, and a command offered while busy is ignored.
- R10: An element that fails the R3/R4 checks stops the list. Earlier elements stay copied, later ones are not fetched, and done_err=1.
- R11: At most one port requests in any cycle. A source read is always followed by the matching destination write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered; taken when busy is low |
| cmd_put | input | 1 | 1 = put (local to remote), 0 = get |
| cmd_list | input | 1 | 1 = gather list, 0 = single block |
| cmd_tag | input | TAG_W | Tag returned with completion |
| cmd_laddr | input | ADDR_W | Local start address |
| cmd_raddr | input | ADDR_W | Remote address (single block) |
| cmd_size | input | SZ_W | Byte size (single block) |
| cmd_list_addr | input | ADDR_W | Local address of the element list |
| cmd_count | input | CNT_W | Number of list elements |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of completed command |
| done_err | output | 1 | Command was rejected or stopped |
| l_req | output | 1 | Local port request |
| l_we | output | 1 | Local port write (1) or read (0) |
| l_addr | output | ADDR_W | Local byte address |
| l_wdata | output | DATA_W | Local write data |
| l_rdata | input | DATA_W | Local read data, valid with l_ready |
| l_ready | input | 1 | Local port accepts the request |
| r_req | output | 1 | Remote port request |
| r_we | output | 1 | Remote port write (1) or read (0) |
| r_addr | output | ADDR_W | Remote byte address |
| r_wdata | output | DATA_W | Remote write data |
| r_rdata | input | DATA_W | Remote read data, valid with r_ready |
| r_ready | input | 1 | Remote port accepts the request |

## Verification
The bench builds the engine with ADDR_W=12, DATA_W=32, MAX_BLOCK=64 and MAX_LIST=4. A beat is then four bytes, and the whole legal size range is only sixteen values, so every size is run in both directions. This small setting also puts the size limit, the shortest and longest lists, and the counts on either side of the limits within a few cycles of each other. Whole-memory comparisons against a bench model then cover both address spaces after every command, under full-speed and randomly stalled ready.

// File: rtl/dma_list_pkg.sv
package dma_list_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ELEM,
    ST_MOVE,
    ST_DONE
  } eng_state_e;

  function automatic logic is_aligned(input logic [31:0] addr, input logic [31:0] beat_b);
    return (addr % beat_b) == 32'd0;
  endfunction

  function automatic logic block_ok(input logic [31:0] laddr, input logic [31:0] raddr,
                                    input logic [31:0] size, input logic [31:0] max_block,
                                    input logic [31:0] beat_b);
    return (size != 32'd0) && (size <= max_block) && ((size % beat_b) == 32'd0) &&
           is_aligned(laddr, beat_b) && is_aligned(raddr, beat_b);
  endfunction

  function automatic logic count_ok(input logic [31:0] n, input logic [31:0] lo,
                                    input logic [31:0] hi);
    return (n >= lo) && (n <= hi);
  endfunction

  function automatic logic [31:0] beats_of(input logic [31:0] size, input logic [31:0] beat_b);
    return size / beat_b;
  endfunction

endpackage

// File: rtl/dma_elem_check.sv
module dma_elem_check
  import dma_list_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SZ_W      = 16,
  parameter int MAX_BLOCK = 16384,
  parameter int BEAT_B    = 16
) (
  input  logic [ADDR_W-1:0] laddr,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [SZ_W-1:0]   size,
  output logic              ok
);
  assign ok = block_ok(32'(laddr), 32'(raddr), 32'(size), 32'(MAX_BLOCK), 32'(BEAT_B));
endmodule

// File: rtl/dma_beat_mover.sv
module dma_beat_mover #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int BC_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              put,
  input  logic [ADDR_W-1:0] laddr,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [BC_W-1:0]   nbeats,
  output logic              l_req,
  output logic              l_we,
  output logic [ADDR_W-1:0] l_addr,
  output logic [DATA_W-1:0] l_wdata,
  input  logic [DATA_W-1:0] l_rdata,
  input  logic              l_ready,
  output logic              r_req,
  output logic              r_we,
  output logic [ADDR_W-1:0] r_addr,
  output logic [DATA_W-1:0] r_wdata,
  input  logic [DATA_W-1:0] r_rdata,
  input  logic              r_ready,
  output logic              beat_read,
  output logic              beat_write,
  output logic              last
);
  localparam int BEAT_B = DATA_W / 8;

  logic              act_q, wr_ph_q;
  logic [ADDR_W-1:0] la_q, ra_q;
  logic [BC_W-1:0]   cnt_q;
  logic [DATA_W-1:0] beat_q;

  logic              src_req, dst_req, src_ready, dst_ready;
  logic [DATA_W-1:0] src_data;

  assign src_req   = act_q && !wr_ph_q;
  assign dst_req   = act_q && wr_ph_q;
  assign src_ready = put ? l_ready : r_ready;
  assign dst_ready = put ? r_ready : l_ready;
  assign src_data  = put ? l_rdata : r_rdata;

  assign beat_read  = src_req && src_ready;
  assign beat_write = dst_req && dst_ready;
  assign last       = beat_write && (cnt_q == BC_W'(1));

  assign l_req   = put ? src_req : dst_req;
  assign l_we    = !put;
  assign l_addr  = la_q;
  assign l_wdata = beat_q;
  assign r_req   = put ? dst_req : src_req;
  assign r_we    = put;
  assign r_addr  = ra_q;
  assign r_wdata = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_ph_q <= 1'b0;
      la_q    <= '0;
      ra_q    <= '0;
      cnt_q   <= '0;
      beat_q  <= '0;
    end else if (start) begin
      act_q   <= 1'b1;
      wr_ph_q <= 1'b0;
      la_q    <= laddr;
      ra_q    <= raddr;
      cnt_q   <= nbeats;
    end else begin
      if (beat_read) begin
        beat_q  <= src_data;
        wr_ph_q <= 1'b1;
      end
      if (beat_write) begin
        wr_ph_q <= 1'b0;
        la_q    <= la_q + ADDR_W'(BEAT_B);
        ra_q    <= ra_q + ADDR_W'(BEAT_B);
        cnt_q   <= cnt_q - BC_W'(1);
        if (cnt_q == BC_W'(1)) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_list_engine.sv
module dma_list_engine
  import dma_list_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 128,
  parameter int MAX_BLOCK = 16384,
  parameter int MIN_LIST  = 2,
  parameter int MAX_LIST  = 2048,
  parameter int TAG_W     = 8,
  localparam int BEAT_B   = DATA_W / 8,
  localparam int SZ_W     = $clog2(MAX_BLOCK) + 2,
  localparam int CNT_W    = $clog2(MAX_LIST) + 2,
  localparam int BC_W     = $clog2(MAX_BLOCK / BEAT_B) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_put,
  input  logic              cmd_list,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [ADDR_W-1:0] cmd_laddr,
  input  logic [ADDR_W-1:0] cmd_raddr,
  input  logic [SZ_W-1:0]   cmd_size,
  input  logic [ADDR_W-1:0] cmd_list_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              busy,
  output logic              done,
  output logic [TAG_W-1:0]  done_tag,
  output logic              done_err,
  output logic              l_req,
  output logic              l_we,
  output logic [ADDR_W-1:0] l_addr,
  output logic [DATA_W-1:0] l_wdata,
  input  logic [DATA_W-1:0] l_rdata,
  input  logic              l_ready,
  output logic              r_req,
  output logic              r_we,
  output logic [ADDR_W-1:0] r_addr,
  output logic [DATA_W-1:0] r_wdata,
  input  logic [DATA_W-1:0] r_rdata,
  input  logic              r_ready
);
  eng_state_e        state_q;
  logic              put_q, err_q;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] cur_l, cur_r, list_ptr;
  logic [SZ_W-1:0]   cur_sz;
  logic [CNT_W-1:0]  left_q;

  logic              elem_ok, list_ok, fetch_req, mv_start;
  logic              mv_l_req, mv_l_we, mv_beat_read, mv_beat_write, mv_last;
  logic [ADDR_W-1:0] mv_l_addr;
  logic [BC_W-1:0]   mv_beats;

  assign list_ok = count_ok(32'(cmd_count), 32'(MIN_LIST), 32'(MAX_LIST)) &&
                   is_aligned(32'(cmd_list_addr), 32'(BEAT_B));
  assign fetch_req = (state_q == ST_FETCH);
  assign mv_start  = (state_q == ST_ELEM) && elem_ok;
  assign mv_beats  = BC_W'(beats_of(32'(cur_sz), 32'(BEAT_B)));

  dma_elem_check #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MAX_BLOCK(MAX_BLOCK), .BEAT_B(BEAT_B)
  ) elem_chk_i (
    .laddr(cur_l), .raddr(cur_r), .size(cur_sz), .ok(elem_ok)
  );

  dma_beat_mover #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BC_W(BC_W)
  ) mover_i (
    .clk(clk), .rst_n(rst_n), .start(mv_start), .put(put_q),
    .laddr(cur_l), .raddr(cur_r), .nbeats(mv_beats),
    .l_req(mv_l_req), .l_we(mv_l_we), .l_addr(mv_l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_ready(l_ready),
    .r_req(r_req), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_ready(r_ready),
    .beat_read(mv_beat_read), .beat_write(mv_beat_write), .last(mv_last)
  );

  assign l_req  = fetch_req | mv_l_req;
  assign l_we   = fetch_req ? 1'b0 : mv_l_we;
  assign l_addr = fetch_req ? list_ptr : mv_l_addr;

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign done_tag = tag_q;
  assign done_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      put_q    <= 1'b0;
      err_q    <= 1'b0;
      tag_q    <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      cur_sz   <= '0;
      list_ptr <= '0;
      left_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          tag_q <= cmd_tag;
          put_q <= cmd_put;
          err_q <= 1'b0;
          cur_l <= cmd_laddr;
          if (cmd_list) begin
            list_ptr <= cmd_list_addr;
            left_q   <= cmd_count;
            err_q    <= !list_ok;
            state_q  <= list_ok ? ST_FETCH : ST_DONE;
          end else begin
            cur_r   <= cmd_raddr;
            cur_sz  <= cmd_size;
            left_q  <= CNT_W'(1);
            state_q <= ST_ELEM;
          end
        end
        ST_FETCH: if (l_ready) begin
          cur_r    <= l_rdata[ADDR_W-1:0];
          cur_sz   <= l_rdata[ADDR_W +: SZ_W];
          list_ptr <= list_ptr + ADDR_W'(BEAT_B);
          state_q  <= ST_ELEM;
        end
        ST_ELEM: if (elem_ok) begin
          state_q <= ST_MOVE;
        end else begin
          err_q   <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_MOVE: if (mv_last) begin
          cur_l   <= cur_l + ADDR_W'(cur_sz);
          left_q  <= left_q - CNT_W'(1);
          state_q <= (left_q == CNT_W'(1)) ? ST_DONE : ST_FETCH;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_list_engine_chk.sv
module dma_list_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              l_req,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic              l_ready,
  input logic              r_req,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic              r_ready,
  input logic              mv_beat_read
);
  localparam int BEAT_B = DATA_W / 8;

  p_hold_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    l_req && !l_ready |=> l_req && $stable(l_addr) && $stable(l_we) && $stable(l_wdata));

  p_hold_remote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    r_req && !r_ready |=> r_req && $stable(r_addr) && $stable(r_we) && $stable(r_wdata));

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_req && r_req));

  p_read_then_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mv_beat_read |=> (l_req && l_we) || (r_req && r_we));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !l_req && !r_req && !done);

  p_take_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy |=> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_local_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    l_req |-> (32'(l_addr) % BEAT_B) == 0);

  p_remote_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    r_req |-> (32'(r_addr) % BEAT_B) == 0);
endmodule

bind dma_list_engine dma_list_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .l_req(l_req), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_ready(l_ready),
  .r_req(r_req), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_ready(r_ready),
  .mv_beat_read(mv_beat_read)
);

// File: tb/dma_list_engine_tb_top.sv
module dma_list_engine_tb_top;
  localparam int AW = 12, DW = 32, MAXB = 64, MAXL = 4, TW = 4;
  localparam int SZW = 8, CW = 4, WORDS = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_put = 0, cmd_list = 0;
  logic [TW-1:0] cmd_tag = '0;
  logic [AW-1:0] cmd_laddr = '0, cmd_raddr = '0, cmd_list_addr = '0;
  logic [SZW-1:0] cmd_size = '0;
  logic [CW-1:0] cmd_count = '0;
  logic busy, done, done_err;
  logic [TW-1:0] done_tag;
  logic l_req, l_we, r_req, r_we, l_ready, r_ready;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  dma_list_engine #(.ADDR_W(AW), .DATA_W(DW), .MAX_BLOCK(MAXB), .MIN_LIST(2),
                    .MAX_LIST(MAXL), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_put(cmd_put), .cmd_list(cmd_list),
    .cmd_tag(cmd_tag), .cmd_laddr(cmd_laddr), .cmd_raddr(cmd_raddr), .cmd_size(cmd_size),
    .cmd_list_addr(cmd_list_addr), .cmd_count(cmd_count), .busy(busy), .done(done),
    .done_tag(done_tag), .done_err(done_err),
    .l_req(l_req), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_ready(l_ready), .r_req(r_req), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_ready(r_ready));

  logic [31:0] lmem [WORDS], rmem [WORDS];
  logic [31:0] img_l [WORDS], img_r [WORDS], exp_l [WORDS], exp_r [WORDS];
  logic do_fill = 0, fast = 1;
  logic [7:0] lfsr = 8'h5B;
  int lw_cnt = 0, rw_cnt = 0;
  int errors = 0, checks = 0, cycles = 0;

  assign l_rdata = lmem[l_addr[11:2]];
  assign r_rdata = rmem[r_addr[11:2]];
  assign l_ready = fast | lfsr[0];
  assign r_ready = fast | lfsr[5];

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    if (do_fill) begin
      for (int i = 0; i < WORDS; i++) begin
        lmem[i] <= img_l[i];
        rmem[i] <= img_r[i];
      end
      lw_cnt <= 0;
      rw_cnt <= 0;
    end else begin
      if (l_req && l_we && l_ready) begin lmem[l_addr[11:2]] <= l_wdata; lw_cnt <= lw_cnt + 1; end
      if (r_req && r_we && r_ready) begin rmem[r_addr[11:2]] <= r_wdata; rw_cnt <= rw_cnt + 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic prep(input int seed);
    for (int i = 0; i < WORDS; i++) begin
      img_l[i] = {8'hA5, 8'(seed), 6'd0, 10'(i)};
      img_r[i] = {8'h5A, 8'(seed), 6'd0, 10'(i)} ^ 32'h0000_3C00;
      exp_l[i] = img_l[i];
      exp_r[i] = img_r[i];
    end
  endtask

  task automatic load();
    @(negedge clk) do_fill = 1;
    @(negedge clk) do_fill = 0;
  endtask

  function automatic bit blk_ok(input int l, input int r, input int s);
    return s > 0 && s <= MAXB && s % 4 == 0 && l % 4 == 0 && r % 4 == 0;
  endfunction

  task automatic model_blk(input bit put, input int l, input int r, input int s);
    for (int k = 0; k < s / 4; k++)
      if (put) exp_r[r / 4 + k] = exp_l[l / 4 + k];
      else     exp_l[l / 4 + k] = exp_r[r / 4 + k];
  endtask

  task automatic run(input bit put, input bit lst, input int tag, input int la, input int ra,
                     input int sz, input int lp, input int cnt, input bit eerr,
                     input int ewl, input int ewr, input string req, input bit inject);
    bit got = 0;
    int mis = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_put = put; cmd_list = lst; cmd_tag = TW'(tag);
    cmd_laddr = AW'(la); cmd_raddr = AW'(ra); cmd_size = SZW'(sz);
    cmd_list_addr = AW'(lp); cmd_count = CW'(cnt);
    @(negedge clk);
    cmd_valid = 0;
    if (inject) begin
      // R9: offer a different put while busy
      cmd_valid = 1; cmd_put = 1; cmd_list = 0; cmd_tag = TW'(tag ^ 15);
      cmd_laddr = 12'h000; cmd_raddr = 12'hC00; cmd_size = 8'd16;
      chk(busy == 1'b1, "R9", "busy while running", int'(busy), 1);
      @(negedge clk);
      cmd_valid = 0;
    end
    for (int c = 0; c < 3000; c++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, req, "done seen", int'(got), 1);
    chk(done_tag == TW'(tag), "R8", "done tag", int'(done_tag), tag);
    chk(done_err == eerr, req, "error flag", int'(done_err), int'(eerr));
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", int'(done), 0);
    for (int i = 0; i < WORDS; i++) begin
      if (lmem[i] !== exp_l[i]) mis++;
      if (rmem[i] !== exp_r[i]) mis++;
    end
    chk(mis == 0, req, "memory mismatch words", mis, 0);
    chk(lw_cnt == ewl && rw_cnt == ewr, req, "local*1000+remote writes",
        lw_cnt * 1000 + rw_cnt, ewl * 1000 + ewr);
  endtask

  int el_r [4], el_s [4];

  task automatic run_list(input bit put, input int tag, input int n, input int la,
                          input int lp, input int cnt, input string req);
    int cur = la, nw = 0;
    bit err = 0;
    prep(tag + 40);
    for (int k = 0; k < n; k++) begin
      img_l[lp / 4 + k] = {12'd0, 8'(el_s[k]), 12'(el_r[k])};
      exp_l[lp / 4 + k] = img_l[lp / 4 + k];
    end
    if (cnt < 2 || cnt > MAXL) err = 1;
    else
      for (int k = 0; k < cnt; k++) begin
        if (!blk_ok(cur, el_r[k], el_s[k])) begin err = 1; break; end
        model_blk(put, cur, el_r[k], el_s[k]);
        nw += el_s[k] / 4;
        cur += el_s[k];
      end
    load();
    run(put, 1, tag, la, 0, 0, lp, cnt, err, put ? 0 : nw, put ? nw : 0, req, 0);
  endtask

  initial begin
    prep(0);
    load();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(busy == 0 && done == 0, "R9", "idle after reset busy|done", int'(busy) + int'(done), 0);
    chk(l_req == 0 && r_req == 0, "R9", "ports quiet after reset", int'(l_req) + int'(r_req), 0);

    // R1/R2: every legal size, both directions, alternating stall mode
    for (int put = 0; put < 2; put++)
      for (int sz = 4; sz <= MAXB; sz += 4) begin
        int la = 12'h100 + sz * 4, ra = 12'h800 + sz * 2;
        fast = ((sz / 4) % 2 == 0);
        prep(sz + put * 20);
        model_blk(put[0], la, ra, sz);
        load();
        run(put[0], 0, sz / 4, la, ra, sz, 0, 0, 0, put ? 0 : sz / 4, put ? sz / 4 : 0,
            put ? "R2" : "R1", 0);
      end

    // R3: zero and oversize; R4: partial beat and misaligned addresses
    fast = 0;
    for (int put = 0; put < 2; put++) begin
      prep(90 + put); load();
      run(put[0], 0, 1, 12'h100, 12'h800, 0, 0, 0, 1, 0, 0, "R3", 0);
      run(put[0], 0, 2, 12'h100, 12'h800, MAXB + 4, 0, 0, 1, 0, 0, "R3", 0);
      run(put[0], 0, 3, 12'h100, 12'h800, 6, 0, 0, 1, 0, 0, "R4", 0);
      run(put[0], 0, 4, 12'h102, 12'h800, 8, 0, 0, 1, 0, 0, "R4", 0);
      run(put[0], 0, 5, 12'h100, 12'h801, 8, 0, 0, 1, 0, 0, "R4", 0);
    end

    // R6: lists of every legal length, both directions
    for (int put = 0; put < 2; put++)
      for (int n = 2; n <= MAXL; n++) begin
        for (int k = 0; k < 4; k++) begin
          el_r[k] = 12'h400 + k * 12'h0C0 + n * 4;
          el_s[k] = ((k * 5 + n) % 16 + 1) * 4;
        end
        fast = (n == 3);
        run_list(put[0], n + put * 4, n, 12'h200 + n * 8, 12'hE00, n, "R6");
      end

    // R5: counts outside the range and a misaligned list address
    fast = 1;
    run_list(0, 9, 4, 12'h200, 12'hE00, 0, "R5");
    run_list(1, 10, 4, 12'h200, 12'hE00, 1, "R5");
    run_list(0, 11, 4, 12'h200, 12'hE00, 5, "R5");
    prep(60); load();
    run(1, 1, 12, 12'h200, 0, 0, 12'hE02, 2, 1, 0, 0, "R5", 0);

    // R10: second element oversize stops the list after the first
    fast = 0;
    el_r[0] = 12'h400; el_s[0] = 32;
    el_r[1] = 12'h500; el_s[1] = MAXB + 4;
    el_r[2] = 12'h600; el_s[2] = 16;
    run_list(0, 13, 3, 12'h200, 12'hE00, 3, "R10");
    el_s[1] = 12;
    el_r[1] = 12'h502;
    run_list(1, 14, 3, 12'h200, 12'hE00, 3, "R10");

    // R9 + R7: command offered while busy is ignored, stalled transfer intact
    prep(77);
    model_blk(0, 12'h300, 12'h900, MAXB);
    load();
    run(0, 0, 3, 12'h300, 12'h900, MAXB, 0, 0, 0, MAXB / 4, 0, "R9", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule